// File: doc/BRIEF.md
# Buffer-Level Watermark Rate Controller

This block sits beside a transfer buffer that carries samples from a producer clocked by one oscillator to a consumer clocked by another. It looks at the buffer's occupancy only on a periodic sample tick. It holds the consumer off until the buffer is half full. After that it compares each sampled occupancy with a high and a low watermark. If the consumer falls behind, the fill climbs past the high mark. If the consumer runs ahead, the fill sinks below the low mark.

A watermark crossing only counts once it has held for a programmable number of consecutive ticks. This dwell filter stops the controller from chasing the sawtooth that chunked arrivals put on the occupancy. In steering mode, every qualifying tick sets a faster or slower rate command and moves a signed correction word by one step, up to a symmetric limit. That word drives a downstream clock trim or interpolator. In slip mode the block leaves the word alone and instead asks for one dropped sample (buffer high) or one repeated sample (buffer low) per qualifying tick.

No data stream passes through the block. Every pin is a plain control or status level or strobe, and there is no back-pressure. A typical sizing is a buffer that holds 240 ms of input, with a 120 ms preroll, drained in 6 ms chunks.

Top module: `buf_level_rate_ctrl`

## Requirements
- R1: While reset is asserted and on the cycle after it, consume_en is 0, rate_cmd is 2'b00 (hold), corr_word is 0, and slip_repeat and slip_drop are 0.
- R2: consume_en goes to 1 one cycle after the first tick on which fill_level >= buf_capacity/2 (the capacity shifted right by one). It then stays at 1 until reset.
- R3: Before consume_en is 1, rate_cmd stays at hold, corr_word stays at 0 and no slip strobe is issued, whatever the fill level.
- R4: On a tick with consume_en at 1, fill_level > high_mark puts the tick in the high zone. Once the high zone has held for dwell_ticks consecutive ticks (a dwell of 0 acts as 1), every further high tick in steering mode (slip_mode=0) is a qualifying tick: it sets rate_cmd to 2'b01 (faster) and adds corr_step to corr_word.
- R5: fill_level < low_mark puts the tick in the low zone. Qualifying low ticks in steering mode set rate_cmd to 2'b10 (slower) and subtract corr_step from corr_word.
- R6: A tick in the middle zone (low_mark <= fill_level <= high_mark), or a tick in the opposite zone, restarts the consecutive count. Excursions shorter than the dwell therefore leave rate_cmd at hold and corr_word unchanged.
- R7: corr_word saturates at +corr_limit and at -corr_limit.
- R8: A tick that is not qualifying sets rate_cmd to hold and leaves corr_word unchanged.
- R9: rate_cmd and corr_word change only in the cycle after a tick.
- R10: In slip mode (slip_mode=1), a qualifying high tick pulses slip_drop and a qualifying low tick pulses slip_repeat. Each pulse is one cycle, at most one per tick, and the two never occur together. rate_cmd stays at hold and corr_word stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | Occupancy sampling strobe |
| fill_level | input | LVL_W | Current buffer occupancy |
| buf_capacity | input | LVL_W | Buffer capacity; half of it is the preroll level |
| high_mark | input | LVL_W | Upper watermark |
| low_mark | input | LVL_W | Lower watermark |
| dwell_ticks | input | CNT_W | Consecutive ticks needed to qualify |
| corr_step | input | CORR_W-1 | Correction increment per qualifying tick |
| corr_limit | input | CORR_W-1 | Correction magnitude limit |
| slip_mode | input | 1 | 0 steers the rate, 1 issues slip strobes |
| consume_en | output | 1 | Consumer may start draining |
| rate_cmd | output | 2 | 00 hold, 01 faster, 10 slower |
| corr_word | output | CORR_W | Signed correction, positive means faster |
| slip_repeat | output | 1 | Repeat one output sample |
| slip_drop | output | 1 | Drop one output sample |

## Verification
Several occupancy patterns are applied:
- A preroll ramp that stops just under half and then reaches it separates the preroll gate from the watermark logic.
- A steady mid-level fill shows that matched clocks leave the loop quiet.
- A chunk-like sawtooth that pokes past the high mark for one tick at a time must not provoke any action, which isolates the dwell filter.
- Long high and long low stretches drive the correction into both saturation limits.
- The same stretches in slip mode count drop and repeat strobes against the number of qualifying ticks.
- A zero dwell checks that one tick is enough to qualify.

// File: rtl/blrc_pkg.sv
package blrc_pkg;
  typedef enum logic [1:0] {
    RATE_HOLD   = 2'b00,
    RATE_FASTER = 2'b01,
    RATE_SLOWER = 2'b10
  } rate_cmd_e;

  typedef enum logic [1:0] {
    ZN_MID  = 2'b00,
    ZN_HIGH = 2'b01,
    ZN_LOW  = 2'b10
  } zone_e;
endpackage

// File: rtl/blrc_zone_sense.sv
module blrc_zone_sense
  import blrc_pkg::*;
#(
  parameter int LVL_W = 16
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] hi_i,
  input  logic [LVL_W-1:0] lo_i,
  output zone_e            zone_o
);
  always_comb begin
    if (level_i > hi_i)      zone_o = ZN_HIGH;
    else if (level_i < lo_i) zone_o = ZN_LOW;
    else                     zone_o = ZN_MID;
  end
endmodule

// File: rtl/blrc_streak.sv
module blrc_streak
  import blrc_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_act_i,
  input  zone_e            zone_i,
  input  logic [CNT_W-1:0] dwell_i,
  output logic             qualify_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] run_q, run_n, dwell_eff;
  zone_e            zone_q;

  always_comb begin
    if (zone_i != zone_q)     run_n = CNT_ONE;
    else if (run_q == CNT_MAX) run_n = run_q;
    else                       run_n = run_q + CNT_ONE;
    dwell_eff = (dwell_i == '0) ? CNT_ONE : dwell_i;
    qualify_o = tick_act_i && (zone_i != ZN_MID) && (run_n >= dwell_eff);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      zone_q <= ZN_MID;
    end else if (tick_act_i) begin
      run_q  <= (zone_i == ZN_MID) ? '0 : run_n;
      zone_q <= zone_i;
    end
  end

  AST_STREAK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_act_i && zone_i == ZN_MID) |=> (run_q == '0)); // R6
endmodule

// File: rtl/blrc_corr_acc.sv
module blrc_corr_acc #(
  parameter int CORR_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     up_i,
  input  logic                     down_i,
  input  logic [CORR_W-2:0]        step_i,
  input  logic [CORR_W-2:0]        limit_i,
  output logic signed [CORR_W-1:0] corr_o
);
  localparam int EW = CORR_W + 1;

  logic signed [EW-1:0] cur, stepx, limx, nxt;

  always_comb begin
    cur   = {corr_o[CORR_W-1], corr_o};
    stepx = {2'b00, step_i};
    limx  = {2'b00, limit_i};
    nxt   = cur;
    if (up_i) begin
      nxt = cur + stepx;
      if (nxt > limx) nxt = limx;
    end else if (down_i) begin
      nxt = cur - stepx;
      if (nxt < -limx) nxt = -limx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) corr_o <= '0;
    else        corr_o <= nxt[CORR_W-1:0];
  end

  AST_CORR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_i && !down_i) |=> $stable(corr_o)); // R8
endmodule

// File: rtl/buf_level_rate_ctrl.sv
module buf_level_rate_ctrl
  import blrc_pkg::*;
#(
  parameter int LVL_W  = 16,
  parameter int CNT_W  = 6,
  parameter int CORR_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sample_tick,
  input  logic [LVL_W-1:0]         fill_level,
  input  logic [LVL_W-1:0]         buf_capacity,
  input  logic [LVL_W-1:0]         high_mark,
  input  logic [LVL_W-1:0]         low_mark,
  input  logic [CNT_W-1:0]         dwell_ticks,
  input  logic [CORR_W-2:0]        corr_step,
  input  logic [CORR_W-2:0]        corr_limit,
  input  logic                     slip_mode,
  output logic                     consume_en,
  output logic [1:0]               rate_cmd,
  output logic signed [CORR_W-1:0] corr_word,
  output logic                     slip_repeat,
  output logic                     slip_drop
);
  logic [LVL_W-1:0] preroll_lvl;
  logic             tick_act, qualify, steer_up, steer_dn;
  zone_e            zone;
  rate_cmd_e        cmd_q;

  assign preroll_lvl = {1'b0, buf_capacity[LVL_W-1:1]};
  assign tick_act    = sample_tick && consume_en;

  blrc_zone_sense #(.LVL_W(LVL_W)) u_zone (
    .level_i (fill_level),
    .hi_i    (high_mark),
    .lo_i    (low_mark),
    .zone_o  (zone)
  );

  blrc_streak #(.CNT_W(CNT_W)) u_streak (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_act_i (tick_act),
    .zone_i     (zone),
    .dwell_i    (dwell_ticks),
    .qualify_o  (qualify)
  );

  assign steer_up = qualify && !slip_mode && (zone == ZN_HIGH);
  assign steer_dn = qualify && !slip_mode && (zone == ZN_LOW);

  blrc_corr_acc #(.CORR_W(CORR_W)) u_corr (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_i    (steer_up),
    .down_i  (steer_dn),
    .step_i  (corr_step),
    .limit_i (corr_limit),
    .corr_o  (corr_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      consume_en  <= 1'b0;
      cmd_q       <= RATE_HOLD;
      slip_repeat <= 1'b0;
      slip_drop   <= 1'b0;
    end else begin
      slip_repeat <= qualify && slip_mode && (zone == ZN_LOW);
      slip_drop   <= qualify && slip_mode && (zone == ZN_HIGH);
      if (sample_tick && !consume_en && fill_level >= preroll_lvl)
        consume_en <= 1'b1;
      if (tick_act) begin
        if (steer_up)      cmd_q <= RATE_FASTER;
        else if (steer_dn) cmd_q <= RATE_SLOWER;
        else               cmd_q <= RATE_HOLD;
      end
    end
  end

  assign rate_cmd = cmd_q;

  AST_IDLE_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    !consume_en |-> (rate_cmd == RATE_HOLD && !slip_repeat && !slip_drop)); // R3
  AST_START_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    consume_en |=> consume_en); // R2
  AST_SLIP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({slip_repeat, slip_drop})); // R10
  AST_SLIP_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_repeat || slip_drop) |-> $past(sample_tick)); // R10
  AST_CMD_QUIET_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick |=> ($stable(rate_cmd) && $stable(corr_word))); // R9
endmodule

// File: tb/buf_level_rate_ctrl_tb.sv
module buf_level_rate_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W = 16, CNT_W = 6, CORR_W = 12;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, sample_tick = 1'b0, slip_mode = 1'b0;
  logic [LVL_W-1:0] fill_level = '0, buf_capacity = 16'd1000;
  logic [LVL_W-1:0] high_mark = 16'd700, low_mark = 16'd300;
  logic [CNT_W-1:0] dwell_ticks = 6'd3;
  logic [CORR_W-2:0] corr_step = 11'd40, corr_limit = 11'd100;
  logic consume_en, slip_repeat, slip_drop;
  logic [1:0] rate_cmd;
  logic signed [CORR_W-1:0] corr_word;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_en = 0, m_cmd = 0, m_corr = 0, m_rep = 0, m_drop = 0, m_cnt = 0, m_pz = 0;
  int drop_tot = 0, rep_tot = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  buf_level_rate_ctrl #(.LVL_W(LVL_W), .CNT_W(CNT_W), .CORR_W(CORR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .fill_level(fill_level),
    .buf_capacity(buf_capacity), .high_mark(high_mark), .low_mark(low_mark),
    .dwell_ticks(dwell_ticks), .corr_step(corr_step), .corr_limit(corr_limit),
    .slip_mode(slip_mode), .consume_en(consume_en), .rate_cmd(rate_cmd),
    .corr_word(corr_word), .slip_repeat(slip_repeat), .slip_drop(slip_drop));

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference, evaluated on every rising edge
  always @(posedge clk) begin
    int z, q, dw;
    cyc++;
    m_rep = 0; m_drop = 0;
    if (!rst_n) begin
      m_en = 0; m_cmd = 0; m_corr = 0; m_cnt = 0; m_pz = 0;
    end else if (sample_tick) begin
      if (m_en == 0) begin
        if (int'(fill_level) >= int'(buf_capacity) / 2) m_en = 1;
      end else begin
        z = (fill_level > high_mark) ? 1 : (fill_level < low_mark) ? 2 : 0;
        dw = (dwell_ticks == 0) ? 1 : int'(dwell_ticks);
        q = 0;
        if (z == 0) m_cnt = 0;
        else begin
          m_cnt = (z == m_pz) ? ((m_cnt < CNT_MAX) ? m_cnt + 1 : m_cnt) : 1;
          q = (m_cnt >= dw) ? 1 : 0;
        end
        m_pz = z;
        m_cmd = 0;
        if (q == 1) begin
          if (slip_mode) begin
            if (z == 1) m_drop = 1; else m_rep = 1;
          end else if (z == 1) begin
            m_cmd = 1;
            m_corr = m_corr + int'(corr_step);
            if (m_corr > int'(corr_limit)) m_corr = int'(corr_limit);
          end else begin
            m_cmd = 2;
            m_corr = m_corr - int'(corr_step);
            if (m_corr < -int'(corr_limit)) m_corr = -int'(corr_limit);
          end
        end
      end
    end
    #1;
    check("R2 consume_en", int'(consume_en), m_en);
    check("R4 rate_cmd", int'(rate_cmd), m_cmd);
    check("R7 corr_word", int'(corr_word), m_corr);
    check("R10 slip_drop", int'(slip_drop), m_drop);
    check("R10 slip_repeat", int'(slip_repeat), m_rep);
    drop_tot += int'(slip_drop);
    rep_tot  += int'(slip_repeat);
  end

  // tick on every second cycle
  always @(negedge clk) sample_tick <= ~sample_tick;

  task automatic hold_level(int lvl, int ncyc);
    @(negedge clk) fill_level = LVL_W'(lvl);
    repeat (ncyc - 1) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 consume_en", int'(consume_en), 0);
    check("R1 rate_cmd", int'(rate_cmd), 0);
    check("R1 corr_word", int'(corr_word), 0);
    check("R1 slips", int'(slip_repeat) + int'(slip_drop), 0);
    rst_n = 1'b1;
    // preroll: just under half, even though it is below the low mark
    hold_level(200, 8);
    hold_level(499, 10);
    check("R2 no start below half", int'(consume_en), 0);
    check("R3 idle cmd", int'(rate_cmd), 0);
    check("R3 idle corr", int'(corr_word), 0);
    hold_level(500, 6);
    check("R2 started at half", int'(consume_en), 1);
    // matched clocks, steady middle
    hold_level(520, 20);
    check("R8 mid cmd", int'(rate_cmd), 0);
    check("R8 mid corr", int'(corr_word), 0);
    // chunk sawtooth: one high tick between mid stretches
    repeat (5) begin
      hold_level(760, 2);
      hold_level(520, 4);
    end
    check("R6 sawtooth cmd", int'(rate_cmd), 0);
    check("R6 sawtooth corr", int'(corr_word), 0);
    // sustained high drives to +limit
    hold_level(750, 20);
    check("R4 faster", int'(rate_cmd), 1);
    check("R7 plus limit", int'(corr_word), 100);
    hold_level(520, 10);
    check("R8 hold after high", int'(rate_cmd), 0);
    check("R8 corr kept", int'(corr_word), 100);
    // sustained low drives to -limit
    hold_level(200, 24);
    check("R5 slower", int'(rate_cmd), 2);
    check("R7 minus limit", int'(corr_word), -100);
    hold_level(520, 6);
    // slip mode
    slip_mode = 1'b1;
    drop_tot = 0; rep_tot = 0;
    hold_level(750, 12);
    hold_level(520, 6);
    check("R10 drop count", drop_tot, 4);
    check("R10 cmd hold", int'(rate_cmd), 0);
    check("R10 corr frozen", int'(corr_word), -100);
    hold_level(250, 12);
    hold_level(520, 6);
    check("R10 repeat count", rep_tot, 4);
    // zero dwell acts as one
    slip_mode = 1'b0;
    dwell_ticks = '0;
    hold_level(750, 2);
    hold_level(520, 4);
    check("R4 zero dwell", int'(corr_word), -60);
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule